// File: doc/BRIEF.md
# Four-Byte Transfer Staging Buffer

This block is a byte-wide staging store with four entries. It sits between a host register port and a serial-bus master engine. The host adds bytes through a valid/ready push port and removes them through a pop request. The oldest byte always sits in slot 0 and is shown on `pop_data`. A pop shifts every remaining byte one slot toward slot 0. When the buffer is empty, `pop_data` shows 0xFF.

At the end of a transfer, the engine can load up to four received bytes in a single cycle and set the fill level directly. A flush control empties the store. Two registered status flags, `has_data` and `is_full`, are updated only by the fill transitions listed below. They are event flags, not a decode of the level, so a bulk load can leave a flag set while the level says otherwise.

Back-pressure follows one rule. A push is taken on a rising clock edge only when `push_valid` and `push_ready` are both high. `push_ready` is low in two cases:
- the buffer holds four bytes and no pop is requested in the same cycle;
- a flush or a load is requested in that cycle.

A pop is a plain request with no handshake. A pop while empty is harmless.

Top module: `xfer_byte_stage`

## Requirements
- R1: After reset the buffer is empty, `has_data` and `is_full` are 0, `pop_data` is 0xFF, and `push_ready` is 1 while no flush or load is requested.
- R2: Bytes pushed one by one come out on `pop_data` in push order. Each accepted pop moves the next byte into slot 0 on the following edge.
- R3: While four bytes are held and `pop_req` is low, `push_ready` is 0 and a push has no effect on the contents or the flags.
- R4: A push that raises the level from 0 to 1 sets `has_data`, and a push that raises it from 3 to 4 sets `is_full`. Other pushes leave both flags unchanged.
- R5: While empty, `pop_data` is 0xFF and a pop changes neither the level nor the flags.
- R6: A pop taken at level 4 clears `is_full`, and a pop taken at level 1 clears `has_data`. Other pops leave both flags unchanged.
- R7: `flush` has top priority. On the next edge it empties the buffer, zeroes all slots and clears both flags. Push, pop and load are ignored in that cycle, and `push_ready` is 0.
- R8: `load_en` without `flush` does the following:
  - it clamps `load_count` to 4, then writes byte i of `load_data` (bits 8i+7..8i) into slot i for each i below the count;
  - it sets the level to the count;
  - it sets `has_data` if the count is at least 1 and `is_full` if the count is 4, and never clears either flag;
  - host push and pop are ignored in that cycle.
- R9: A push and a pop in the same cycle are applied pop first, then push. So `push_ready` stays 1 at level 4 when `pop_req` is high, and the flag effects of the pop are applied before those of the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Host offers a byte |
| push_ready | output | 1 | Buffer can take the offered byte this cycle |
| push_data | input | 8 | Byte offered by the host |
| pop_req | input | 1 | Host removes the byte in slot 0 |
| pop_data | output | 8 | Slot 0, or 0xFF when empty |
| flush | input | 1 | Empty the buffer and clear the flags |
| load_en | input | 1 | Engine bulk load of received bytes |
| load_count | input | 3 | Number of bytes to load, clamped to 4 |
| load_data | input | 32 | Loaded bytes, slot i in bits 8i+7..8i |
| has_data | output | 1 | Event flag: buffer became non-empty |
| is_full | output | 1 | Event flag: buffer became full |

## Verification
The bench goes after four corner cases.
- A push against a full buffer: a design that accepted it would overwrite the last byte or wrap the level, and a later pop would show the wrong byte.
- A simultaneous push and pop at levels 0, 1 and 4: a design that ordered them push first would stall at full, or would drop `has_data` while a byte is held.
- Bulk loads of 0, 2 and more than 4 bytes while a flag is already set: a design that decoded the flags from the level, or did not clamp the count, would show a flag or a level that differs from the model.
- Empty reads: a design that shifted on them would lose the 0xFF marker or disturb the level.

// File: rtl/xfer_stage_pkg.sv
`timescale 1ns/1ps
package xfer_stage_pkg;
  // Which kind of update the buffer performs this cycle, highest priority first.
  typedef enum logic [1:0] {
    OP_FLUSH = 2'd0,
    OP_LOAD  = 2'd1,
    OP_HOST  = 2'd2
  } stage_op_e;
endpackage

// File: rtl/xfer_stage_level.sv
`timescale 1ns/1ps
module xfer_stage_level
  import xfer_stage_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stage_op_e     op,
  input  logic          push_go,
  input  logic          pop_go,
  input  logic [CW-1:0] load_n,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [CW-1:0] after_pop;
  logic [CW-1:0] count_nxt;

  always_comb begin
    after_pop = count - CW'(pop_go);
    unique case (op)
      OP_FLUSH: count_nxt = '0;
      OP_LOAD:  count_nxt = load_n;
      default:  count_nxt = after_pop + CW'(push_go);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_LVL); // R3

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOST && count == '0 && !push_go) |=> count == '0); // R5

  AST_LOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> count == $past(load_n)); // R8
endmodule

// File: rtl/xfer_stage_slots.sv
`timescale 1ns/1ps
module xfer_stage_slots
  import xfer_stage_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stage_op_e           op,
  input  logic                push_go,
  input  logic [DW-1:0]       push_data,
  input  logic                pop_go,
  input  logic [CW-1:0]       count,
  input  logic [CW-1:0]       load_n,
  input  logic [DEPTH*DW-1:0] load_data,
  output logic [DW-1:0]       head
);
  logic [DW-1:0] slot [DEPTH];
  logic [DW-1:0] slot_nxt [DEPTH];
  logic [CW-1:0] base;

  always_comb begin
    base = count - CW'(pop_go);
    for (int i = 0; i < DEPTH; i++) slot_nxt[i] = slot[i];
    unique case (op)
      OP_FLUSH: begin
        for (int i = 0; i < DEPTH; i++) slot_nxt[i] = '0;
      end
      OP_LOAD: begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) < load_n) slot_nxt[i] = load_data[i*DW +: DW];
      end
      default: begin
        // The pop shifts first. The push then lands on the first free slot.
        if (pop_go) begin
          for (int i = 0; i < DEPTH - 1; i++) slot_nxt[i] = slot[i+1];
          slot_nxt[DEPTH-1] = '0;
        end
        for (int i = 0; i < DEPTH; i++)
          if (push_go && CW'(i) == base) slot_nxt[i] = push_data;
      end
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[g] <= '0;
      else        slot[g] <= slot_nxt[g];
    end
  end

  assign head = slot[0];

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH) |=> (slot[0] == '0 && slot[DEPTH-1] == '0)); // R7

  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOST && pop_go && count >= CW'(2)) |=> slot[0] == $past(slot[1])); // R2
endmodule

// File: rtl/xfer_stage_flags.sv
`timescale 1ns/1ps
module xfer_stage_flags
  import xfer_stage_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stage_op_e     op,
  input  logic          push_go,
  input  logic          pop_go,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] load_n,
  output logic          has_data,
  output logic          is_full
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic          has_nxt;
  logic          full_nxt;
  logic [CW-1:0] after_pop;

  always_comb begin
    has_nxt   = has_data;
    full_nxt  = is_full;
    after_pop = count - CW'(pop_go);
    unique case (op)
      OP_FLUSH: begin
        has_nxt  = 1'b0;
        full_nxt = 1'b0;
      end
      OP_LOAD: begin
        if (load_n != '0)      has_nxt  = 1'b1;
        if (load_n == FULL_LVL) full_nxt = 1'b1;
      end
      default: begin
        if (pop_go && count == FULL_LVL) full_nxt = 1'b0;
        if (pop_go && count == CW'(1))   has_nxt  = 1'b0;
        if (push_go && after_pop == '0)  has_nxt  = 1'b1;
        if (push_go && after_pop == FULL_LVL - CW'(1)) full_nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_data <= 1'b0;
      is_full  <= 1'b0;
    end else begin
      has_data <= has_nxt;
      is_full  <= full_nxt;
    end
  end

  AST_FULL_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOST && push_go && !pop_go && count == FULL_LVL - CW'(1)) |=> is_full); // R4

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLUSH) |=> (!has_data && !is_full)); // R7

  AST_LAST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOST && pop_go && !push_go && count == CW'(1)) |=> !has_data); // R6
endmodule

// File: rtl/xfer_byte_stage.sv
`timescale 1ns/1ps
module xfer_byte_stage
  import xfer_stage_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter logic [DW-1:0] EMPTY_BYTE = '1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid,
  output logic                push_ready,
  input  logic [DW-1:0]       push_data,
  input  logic                pop_req,
  output logic [DW-1:0]       pop_data,
  input  logic                flush,
  input  logic                load_en,
  input  logic [CW-1:0]       load_count,
  input  logic [DEPTH*DW-1:0] load_data,
  output logic                has_data,
  output logic                is_full
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  stage_op_e     op;
  logic [CW-1:0] count;
  logic [CW-1:0] load_n;
  logic [DW-1:0] head;
  logic          push_go;
  logic          pop_go;

  always_comb begin
    if (flush)        op = OP_FLUSH;
    else if (load_en) op = OP_LOAD;
    else              op = OP_HOST;
  end

  assign load_n     = (load_count > FULL_LVL) ? FULL_LVL : load_count;
  assign pop_go     = (op == OP_HOST) && pop_req && (count != '0);
  assign push_ready = (op == OP_HOST) && ((count != FULL_LVL) || pop_req);
  assign push_go    = push_valid && push_ready;
  assign pop_data   = (count == '0) ? EMPTY_BYTE : head;

  xfer_stage_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .op(op), .push_go(push_go), .pop_go(pop_go),
    .load_n(load_n), .count(count)
  );

  xfer_stage_slots #(.DW(DW), .DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_n), .op(op), .push_go(push_go), .push_data(push_data),
    .pop_go(pop_go), .count(count), .load_n(load_n), .load_data(load_data),
    .head(head)
  );

  xfer_stage_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .push_go(push_go), .pop_go(pop_go),
    .count(count), .load_n(load_n), .has_data(has_data), .is_full(is_full)
  );

  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_LVL && !pop_req) |-> !push_ready); // R3
endmodule

// File: tb/xfer_byte_stage_test.sv
`timescale 1ns/1ps
module xfer_byte_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [7:0]  push_data = '0;
  logic        pop_req = 1'b0;
  logic [7:0]  pop_data;
  logic        flush = 1'b0;
  logic        load_en = 1'b0;
  logic [2:0]  load_count = '0;
  logic [31:0] load_data = '0;
  logic        has_data;
  logic        is_full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state, kept only in the bench.
  int       m_cnt;
  bit [7:0] m_s [4];
  bit       m_has;
  bit       m_full;

  always #2 clk = ~clk;

  xfer_byte_stage uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data), .flush(flush),
    .load_en(load_en), .load_count(load_count), .load_data(load_data),
    .has_data(has_data), .is_full(is_full)
  );

  function automatic bit [7:0] exp_data();
    return (m_cnt == 0) ? 8'hFF : m_s[0];
  endfunction

  function automatic bit exp_ready(bit pr, bit fl, bit ld);
    return !fl && !ld && (m_cnt < 4 || pr);
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit pv, bit [7:0] pd, bit pr, bit fl, bit ld,
                            bit [2:0] lc, bit [31:0] ldat, bit rdy);
    if (fl) begin
      m_cnt = 0; m_has = 0; m_full = 0;
      for (int i = 0; i < 4; i++) m_s[i] = '0;
    end else if (ld) begin
      int n;
      n = (lc > 3'd4) ? 4 : int'(lc);
      for (int i = 0; i < n; i++) m_s[i] = ldat[i*8 +: 8];
      m_cnt = n;
      if (n >= 1) m_has = 1;
      if (n == 4) m_full = 1;
    end else begin
      if (pr && m_cnt > 0) begin
        if (m_cnt == 4) m_full = 0;
        if (m_cnt == 1) m_has = 0;
        for (int i = 0; i < 3; i++) m_s[i] = m_s[i+1];
        m_s[3] = '0;
        m_cnt--;
      end
      if (pv && rdy) begin
        m_s[m_cnt] = pd;
        m_cnt++;
        if (m_cnt == 1) m_has = 1;
        if (m_cnt == 4) m_full = 1;
      end
    end
  endtask

  task automatic cyc(bit pv, bit [7:0] pd, bit pr, bit fl, bit ld,
                     bit [2:0] lc, bit [31:0] ldat, string tag);
    bit rdy;
    @(negedge clk);
    push_valid = pv; push_data = pd; pop_req = pr;
    flush = fl; load_en = ld; load_count = lc; load_data = ldat;
    #1;
    rdy = exp_ready(pr, fl, ld);
    chk(tag, "pop_data", pop_data, exp_data());
    chk(tag, "push_ready", {7'd0, push_ready}, {7'd0, rdy});
    chk(tag, "has_data", {7'd0, has_data}, {7'd0, m_has});
    chk(tag, "is_full", {7'd0, is_full}, {7'd0, m_full});
    @(posedge clk);
    model_step(pv, pd, pr, fl, ld, lc, ldat, rdy);
  endtask

  task automatic push(bit [7:0] d, string tag);
    cyc(1, d, 0, 0, 0, 3'd0, 32'd0, tag);
  endtask
  task automatic pop(string tag);
    cyc(0, 8'd0, 1, 0, 0, 3'd0, 32'd0, tag);
  endtask
  task automatic idle(string tag);
    cyc(0, 8'd0, 0, 0, 0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_has = 0; m_full = 0;
    for (int i = 0; i < 4; i++) m_s[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle("R1");
    // R4: fill with flag transitions at 0->1 and 3->4
    push(8'h11, "R4"); push(8'h22, "R4"); push(8'h33, "R4"); push(8'h44, "R4");
    idle("R4");
    // R3: push against a full buffer is refused
    push(8'h55, "R3"); idle("R3");
    // R2, R6: drain in order; the full flag drops at 4, has_data drops at 1
    pop("R2"); pop("R6"); pop("R2"); pop("R6"); idle("R6");
    // R5: empty reads
    pop("R5"); pop("R5"); idle("R5");
    // R9: simultaneous push and pop at levels 0, 1 and 4
    cyc(1, 8'hA0, 1, 0, 0, 3'd0, 32'd0, "R9");
    cyc(1, 8'hA1, 1, 0, 0, 3'd0, 32'd0, "R9");
    push(8'hA2, "R9"); push(8'hA3, "R9"); push(8'hA4, "R9");
    cyc(1, 8'hA5, 1, 0, 0, 3'd0, 32'd0, "R9");
    idle("R9");
    // R8: a load of 2 keeps the sticky full flag; then a clamped load and an empty load
    cyc(1, 8'hEE, 1, 0, 1, 3'd2, 32'hD4C3B2A1, "R8");
    pop("R8"); pop("R8"); idle("R8");
    cyc(0, 8'd0, 0, 0, 1, 3'd7, 32'h44332211, "R8");
    pop("R8"); idle("R8");
    cyc(1, 8'h99, 1, 0, 1, 3'd0, 32'hFFFFFFFF, "R8");
    idle("R8");
    // R7: flush wins over push, pop and load
    cyc(1, 8'h77, 1, 1, 1, 3'd4, 32'h01020304, "R7");
    idle("R7"); pop("R7"); idle("R7");

    // Constrained random mix checked against the model
    for (int k = 0; k < 4000; k++) begin
      bit pv, pr, fl, ld;
      pv = ($urandom % 100) < 55;
      pr = ($urandom % 100) < 40;
      fl = ($urandom % 100) < 3;
      ld = ($urandom % 100) < 5;
      cyc(pv, 8'($urandom), pr, fl, ld, 3'($urandom), $urandom, "R2 R9 random");
    end
    idle("R2");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule